// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block resolves interrupt requests for two chained 8-input controllers. The secondary controller reports into input 2 of the primary one, which this block calls the cascade pin. Sixteen request lines arrive as single raise or lower events. The block keeps a request register and an in-service register for each controller. From these and the two mask registers it gives an interrupt-pending flag and the vector of the winning input. It does this combinationally, on the registers as they stand.

The processor acknowledges a vector. The block maps that vector back to one input through the two 8-entry base windows. It then marks the input in service and drops its request, but only when the input is set up as edge-triggered. Two byte-wide edge/level registers hold the trigger mode of each input, and fixed masks limit which of their bits can be written.

A separate interface block decodes commands and supplies the masks, the base vectors and the end-of-interrupt clear strobes. This block holds no command state of its own.

Top module: `casc_irq_resolver`

## Requirements
- R1: A raise event on line n (0..7, n not 2) sets primary request bit n. A raise on line n (8..15) sets secondary request bit n-8 and also primary request bit 2.
- R2: A raise or lower event on line 2 is treated exactly as the same event on line 9.
- R3: A lower event on line n (0..7) clears primary request bit n. A lower on line n (8..15) clears secondary bit n-8. It also clears primary bit 2 when no unmasked secondary request remains.
- R4: `irq_pending` is 1 when (primary request AND NOT primary mask) is nonzero. It is also 1 when primary mask bit 2 is 0 and (secondary request AND NOT secondary mask) is nonzero.
- R5: The selection order, highest first, is primary 0, primary 1, secondary 0..7 (lines 8..15), then primary 3..7. Secondary inputs compete only while primary mask bit 2 is 0.
- R6: `irq_vector` is `pri_base`+n for primary input n and `sec_base`+k for secondary input k. It is 0 when no input is selected.
- R7: An acknowledge whose vector lies in [`pri_base`, `pri_base`+7] selects primary input n = vector-`pri_base`. If that input is unmasked and requesting, the acknowledge sets primary in-service bit n, and clears request bit n when edge/level bit n is 0 (edge).
- R8: An acknowledge outside the primary window but inside [`sec_base`, `sec_base`+7] selects secondary input k. If k is unmasked and requesting, the acknowledge sets secondary in-service bit k and primary in-service bit 2. It clears secondary request bit k if secondary edge/level bit k is 0, and primary request bit 2 if primary edge/level bit 2 is 0.
- R9: An acknowledge whose vector is in neither window, or that selects an input that is not unmasked and requesting, changes no request or in-service bit.
- R10: Both edge/level registers reset to 0. A write with `trig_wr_sel`=0 loads the primary register with data AND 0xF8. With `trig_wr_sel`=1 it loads the secondary register with data AND 0xDE.
- R11: An end-of-interrupt strobe clears the in-service bits named in its mask. A secondary end-of-interrupt also clears primary request bit 2 when the secondary request register is left empty.
- R12: Request, in-service and edge/level updates take effect on the clock edge after the strobe. Pending flag and vector follow the registers with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A line event is present this cycle |
| evt_raise | input | 1 | 1 = raise, 0 = lower |
| evt_line | input | 4 | Line number 0..15 |
| pri_mask | input | 8 | Primary mask, 1 = masked |
| sec_mask | input | 8 | Secondary mask, 1 = masked |
| pri_base | input | 8 | Primary base vector |
| sec_base | input | 8 | Secondary base vector |
| trig_wr_en | input | 1 | Edge/level register write strobe |
| trig_wr_sel | input | 1 | 0 = primary, 1 = secondary register |
| trig_wr_data | input | 8 | Edge/level write data, 1 = level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| pri_eoi_valid | input | 1 | Primary end-of-interrupt strobe |
| pri_eoi_mask | input | 8 | Primary in-service bits to clear |
| sec_eoi_valid | input | 1 | Secondary end-of-interrupt strobe |
| sec_eoi_mask | input | 8 | Secondary in-service bits to clear |
| irq_pending | output | 1 | Interrupt pending |
| irq_vector | output | 8 | Selected vector |
| pri_req | output | 8 | Primary request register |
| sec_req | output | 8 | Secondary request register |
| pri_isr | output | 8 | Primary in-service register |
| sec_isr | output | 8 | Secondary in-service register |
| pri_trig | output | 8 | Primary edge/level register |
| sec_trig | output | 8 | Secondary edge/level register |

## Verification
The acknowledge and raise properties hold only when no line event or end-of-interrupt lands in the same cycle. When a raise and an edge acknowledge hit one bit together, the acknowledge wins, and the properties do not cover that overlap. The directed tasks present one strobe per cycle, for one clock each, and hold masks and base vectors steady around every strobe. The two base windows are kept apart, so every acknowledged vector decodes to exactly one controller.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
    localparam int CHIP_W = 8;
    localparam int IDX_W  = $clog2(CHIP_W);
    localparam int LINE_W = $clog2(2 * CHIP_W);
    localparam int VEC_W  = 8;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_PRI  = 2'd1,
        ACK_SEC  = 2'd2
    } ack_kind_e;

    typedef struct packed {
        ack_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } ack_sel_t;
endpackage

// File: rtl/casc_trig_reg.sv
module casc_trig_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] WR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Bits outside WR_MASK are tied to edge mode permanently.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_data & WR_MASK;
    end
endmodule

// File: rtl/casc_select.sv
module casc_select
    import casc_irq_pkg::*;
#(
    parameter int W    = CHIP_W,
    parameter int CASC = 2,
    parameter int VW   = VEC_W
) (
    input  logic [W-1:0]  pri_req,
    input  logic [W-1:0]  pri_mask,
    input  logic [W-1:0]  sec_req,
    input  logic [W-1:0]  sec_mask,
    input  logic [VW-1:0] pri_base,
    input  logic [VW-1:0] sec_base,
    output logic          pending,
    output logic [VW-1:0] vector
);
    logic [W-1:0] pri_live;
    logic [W-1:0] sec_live;
    logic         sec_gate;

    assign pri_live = pri_req & ~pri_mask;
    assign sec_live = sec_req & ~sec_mask;
    assign sec_gate = ~pri_mask[CASC];
    assign pending  = (|pri_live) | (sec_gate & (|sec_live));

    // Walk from the lowest rank to the highest; later hits override.
    always_comb begin
        vector = '0;
        for (int j = W - 1; j > CASC; j--) begin
            if (pri_live[j])
                vector = pri_base + VW'(j);
        end
        if (sec_gate) begin
            for (int j = W - 1; j >= 0; j--) begin
                if (sec_live[j])
                    vector = sec_base + VW'(j);
            end
        end
        for (int j = CASC - 1; j >= 0; j--) begin
            if (pri_live[j])
                vector = pri_base + VW'(j);
        end
    end
endmodule

// File: rtl/casc_ack_decode.sv
module casc_ack_decode
    import casc_irq_pkg::*;
#(
    parameter int W  = CHIP_W,
    parameter int VW = VEC_W
) (
    input  logic          ack_valid,
    input  logic [VW-1:0] ack_vector,
    input  logic [VW-1:0] pri_base,
    input  logic [VW-1:0] sec_base,
    input  logic [W-1:0]  pri_req,
    input  logic [W-1:0]  pri_mask,
    input  logic [W-1:0]  sec_req,
    input  logic [W-1:0]  sec_mask,
    output ack_sel_t      sel
);
    logic [VW:0] pri_off;
    logic [VW:0] sec_off;
    logic        pri_hit;
    logic        sec_hit;

    assign pri_off = {1'b0, ack_vector} - {1'b0, pri_base};
    assign sec_off = {1'b0, ack_vector} - {1'b0, sec_base};
    assign pri_hit = !pri_off[VW] && (pri_off[VW-1:0] < VW'(W));
    assign sec_hit = !sec_off[VW] && (sec_off[VW-1:0] < VW'(W));

    always_comb begin
        sel.kind = ACK_NONE;
        sel.idx  = '0;
        if (ack_valid) begin
            if (pri_hit) begin
                sel.idx = pri_off[IDX_W-1:0];
                if (pri_req[sel.idx] && !pri_mask[sel.idx])
                    sel.kind = ACK_PRI;
            end else if (sec_hit) begin
                sel.idx = sec_off[IDX_W-1:0];
                if (sec_req[sel.idx] && !sec_mask[sel.idx])
                    sel.kind = ACK_SEC;
            end
        end
    end
endmodule

// File: rtl/casc_req_state.sv
module casc_req_state
    import casc_irq_pkg::*;
#(
    parameter int W    = CHIP_W,
    parameter int CASC = 2,
    parameter int LW   = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic          evt_raise,
    input  logic [LW-1:0] evt_line,
    input  logic [W-1:0]  sec_mask,
    input  ack_sel_t      ack_sel,
    input  logic [W-1:0]  pri_trig,
    input  logic [W-1:0]  sec_trig,
    input  logic          pri_eoi_valid,
    input  logic [W-1:0]  pri_eoi_mask,
    input  logic          sec_eoi_valid,
    input  logic [W-1:0]  sec_eoi_mask,
    output logic [W-1:0]  pri_req,
    output logic [W-1:0]  sec_req,
    output logic [W-1:0]  pri_isr,
    output logic [W-1:0]  sec_isr
);
    localparam logic [LW-1:0] CASC_LINE  = LW'(CASC);
    localparam logic [LW-1:0] REDIR_LINE = LW'(W + 1);

    logic [W-1:0]  pri_req_n, sec_req_n, pri_isr_n, sec_isr_n;
    logic [LW-1:0] line_eff;

    assign line_eff = (evt_line == CASC_LINE) ? REDIR_LINE : evt_line;

    // Order inside one cycle: line event, then acknowledge, then end-of-interrupt.
    always_comb begin
        pri_req_n = pri_req;
        sec_req_n = sec_req;
        pri_isr_n = pri_isr;
        sec_isr_n = sec_isr;

        if (evt_valid) begin
            if (line_eff < LW'(W)) begin
                pri_req_n[line_eff[IDX_W-1:0]] = evt_raise;
            end else begin
                sec_req_n[line_eff[IDX_W-1:0]] = evt_raise;
                if (evt_raise)
                    pri_req_n[CASC] = 1'b1;
                else if ((sec_req_n & ~sec_mask) == '0)
                    pri_req_n[CASC] = 1'b0;
            end
        end

        unique case (ack_sel.kind)
            ACK_PRI: begin
                pri_isr_n[ack_sel.idx] = 1'b1;
                if (!pri_trig[ack_sel.idx])
                    pri_req_n[ack_sel.idx] = 1'b0;
            end
            ACK_SEC: begin
                sec_isr_n[ack_sel.idx] = 1'b1;
                pri_isr_n[CASC]        = 1'b1;
                if (!sec_trig[ack_sel.idx])
                    sec_req_n[ack_sel.idx] = 1'b0;
                if (!pri_trig[CASC])
                    pri_req_n[CASC] = 1'b0;
            end
            default: ;
        endcase

        if (pri_eoi_valid)
            pri_isr_n = pri_isr_n & ~pri_eoi_mask;
        if (sec_eoi_valid) begin
            sec_isr_n = sec_isr_n & ~sec_eoi_mask;
            if (sec_req_n == '0)
                pri_req_n[CASC] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_req <= '0;
            sec_req <= '0;
            pri_isr <= '0;
            sec_isr <= '0;
        end else begin
            pri_req <= pri_req_n;
            sec_req <= sec_req_n;
            pri_isr <= pri_isr_n;
            sec_isr <= sec_isr_n;
        end
    end
endmodule

// File: rtl/casc_irq_resolver.sv
module casc_irq_resolver
    import casc_irq_pkg::*;
#(
    parameter int W    = CHIP_W,
    parameter int CASC = 2,
    parameter logic [W-1:0] PRI_TRIG_MASK = 8'hF8,
    parameter logic [W-1:0] SEC_TRIG_MASK = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_raise,
    input  logic [LINE_W-1:0] evt_line,
    input  logic [W-1:0]      pri_mask,
    input  logic [W-1:0]      sec_mask,
    input  logic [VEC_W-1:0]  pri_base,
    input  logic [VEC_W-1:0]  sec_base,
    input  logic              trig_wr_en,
    input  logic              trig_wr_sel,
    input  logic [W-1:0]      trig_wr_data,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    input  logic              pri_eoi_valid,
    input  logic [W-1:0]      pri_eoi_mask,
    input  logic              sec_eoi_valid,
    input  logic [W-1:0]      sec_eoi_mask,
    output logic              irq_pending,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [W-1:0]      pri_req,
    output logic [W-1:0]      sec_req,
    output logic [W-1:0]      pri_isr,
    output logic [W-1:0]      sec_isr,
    output logic [W-1:0]      pri_trig,
    output logic [W-1:0]      sec_trig
);
    ack_sel_t ack_sel;

    casc_trig_reg #(.W(W), .WR_MASK(PRI_TRIG_MASK)) u_pri_trig (
        .clk(clk), .rst_n(rst_n),
        .wr_en(trig_wr_en && !trig_wr_sel),
        .wr_data(trig_wr_data), .q(pri_trig)
    );

    casc_trig_reg #(.W(W), .WR_MASK(SEC_TRIG_MASK)) u_sec_trig (
        .clk(clk), .rst_n(rst_n),
        .wr_en(trig_wr_en && trig_wr_sel),
        .wr_data(trig_wr_data), .q(sec_trig)
    );

    casc_ack_decode #(.W(W), .VW(VEC_W)) u_ack (
        .ack_valid(ack_valid), .ack_vector(ack_vector),
        .pri_base(pri_base), .sec_base(sec_base),
        .pri_req(pri_req), .pri_mask(pri_mask),
        .sec_req(sec_req), .sec_mask(sec_mask),
        .sel(ack_sel)
    );

    casc_req_state #(.W(W), .CASC(CASC), .LW(LINE_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_raise(evt_raise), .evt_line(evt_line),
        .sec_mask(sec_mask), .ack_sel(ack_sel),
        .pri_trig(pri_trig), .sec_trig(sec_trig),
        .pri_eoi_valid(pri_eoi_valid), .pri_eoi_mask(pri_eoi_mask),
        .sec_eoi_valid(sec_eoi_valid), .sec_eoi_mask(sec_eoi_mask),
        .pri_req(pri_req), .sec_req(sec_req),
        .pri_isr(pri_isr), .sec_isr(sec_isr)
    );

    casc_select #(.W(W), .CASC(CASC), .VW(VEC_W)) u_sel (
        .pri_req(pri_req), .pri_mask(pri_mask),
        .sec_req(sec_req), .sec_mask(sec_mask),
        .pri_base(pri_base), .sec_base(sec_base),
        .pending(irq_pending), .vector(irq_vector)
    );
endmodule

// File: rtl/casc_irq_resolver_chk.sv
module casc_irq_resolver_chk
    import casc_irq_pkg::*;
#(
    parameter int W    = CHIP_W,
    parameter int CASC = 2,
    parameter logic [W-1:0] PRI_TRIG_MASK = 8'hF8,
    parameter logic [W-1:0] SEC_TRIG_MASK = 8'hDE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_raise,
    input logic [LINE_W-1:0] evt_line,
    input logic [W-1:0]      pri_mask,
    input logic [VEC_W-1:0]  pri_base,
    input logic [VEC_W-1:0]  sec_base,
    input logic              trig_wr_en,
    input logic              trig_wr_sel,
    input logic [W-1:0]      trig_wr_data,
    input logic              ack_valid,
    input logic [VEC_W-1:0]  ack_vector,
    input logic              pri_eoi_valid,
    input logic              sec_eoi_valid,
    input logic              irq_pending,
    input logic [VEC_W-1:0]  irq_vector,
    input logic [W-1:0]      pri_req,
    input logic [W-1:0]      sec_req,
    input logic [W-1:0]      pri_isr,
    input logic [W-1:0]      sec_isr,
    input logic [W-1:0]      pri_trig,
    input logic [W-1:0]      sec_trig
);
    logic [VEC_W:0]   p_off, s_off, v_off;
    logic             p_in, s_in, quiet;
    logic [IDX_W-1:0] p_idx;

    assign p_off = {1'b0, ack_vector} - {1'b0, pri_base};
    assign s_off = {1'b0, ack_vector} - {1'b0, sec_base};
    assign v_off = {1'b0, irq_vector} - {1'b0, pri_base};
    assign p_in  = !p_off[VEC_W] && (p_off[VEC_W-1:0] < VEC_W'(W));
    assign s_in  = !s_off[VEC_W] && (s_off[VEC_W-1:0] < VEC_W'(W));
    assign p_idx = p_off[IDX_W-1:0];
    assign quiet = !pri_eoi_valid && !sec_eoi_valid;

    assert_sec_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_raise && evt_line >= LINE_W'(W) && !ack_valid && quiet)
        |=> (sec_req[$past(evt_line[IDX_W-1:0])] && pri_req[CASC]));

    assert_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_raise && evt_line == LINE_W'(CASC) && !ack_valid && quiet)
        |=> (sec_req[1] && pri_req[CASC]));

    assert_pri_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && p_in && pri_req[p_idx] && !pri_mask[p_idx] && !evt_valid && quiet)
        |=> pri_isr[$past(p_idx)]);

    assert_foreign_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !p_in && !s_in && !evt_valid && quiet)
        |=> ($stable(pri_req) && $stable(sec_req) && $stable(pri_isr) && $stable(sec_isr)));

    assert_pri_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr_en && !trig_wr_sel) |=> (pri_trig == ($past(trig_wr_data) & PRI_TRIG_MASK)));

    assert_sec_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr_en && trig_wr_sel) |=> (sec_trig == ($past(trig_wr_data) & SEC_TRIG_MASK)));

    assert_gated_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && pri_mask[CASC])
        |-> (!v_off[VEC_W] && v_off[VEC_W-1:0] < VEC_W'(W)));
endmodule

bind casc_irq_resolver casc_irq_resolver_chk #(
    .W(W), .CASC(CASC), .PRI_TRIG_MASK(PRI_TRIG_MASK), .SEC_TRIG_MASK(SEC_TRIG_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_raise(evt_raise), .evt_line(evt_line),
    .pri_mask(pri_mask), .pri_base(pri_base), .sec_base(sec_base),
    .trig_wr_en(trig_wr_en), .trig_wr_sel(trig_wr_sel), .trig_wr_data(trig_wr_data),
    .ack_valid(ack_valid), .ack_vector(ack_vector),
    .pri_eoi_valid(pri_eoi_valid), .sec_eoi_valid(sec_eoi_valid),
    .irq_pending(irq_pending), .irq_vector(irq_vector),
    .pri_req(pri_req), .sec_req(sec_req), .pri_isr(pri_isr), .sec_isr(sec_isr),
    .pri_trig(pri_trig), .sec_trig(sec_trig)
);

// File: tb/casc_irq_resolver_tb.sv
module casc_irq_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 0, evt_raise = 0;
    logic [3:0] evt_line = 0;
    logic [7:0] pri_mask = 0, sec_mask = 0;
    logic [7:0] pri_base = 8'h20, sec_base = 8'h28;
    logic       trig_wr_en = 0, trig_wr_sel = 0;
    logic [7:0] trig_wr_data = 0;
    logic       ack_valid = 0;
    logic [7:0] ack_vector = 0;
    logic       pri_eoi_valid = 0, sec_eoi_valid = 0;
    logic [7:0] pri_eoi_mask = 0, sec_eoi_mask = 0;
    logic       irq_pending;
    logic [7:0] irq_vector, pri_req, sec_req, pri_isr, sec_isr, pri_trig, sec_trig;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    casc_irq_resolver u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_raise(evt_raise), .evt_line(evt_line),
        .pri_mask(pri_mask), .sec_mask(sec_mask),
        .pri_base(pri_base), .sec_base(sec_base),
        .trig_wr_en(trig_wr_en), .trig_wr_sel(trig_wr_sel), .trig_wr_data(trig_wr_data),
        .ack_valid(ack_valid), .ack_vector(ack_vector),
        .pri_eoi_valid(pri_eoi_valid), .pri_eoi_mask(pri_eoi_mask),
        .sec_eoi_valid(sec_eoi_valid), .sec_eoi_mask(sec_eoi_mask),
        .irq_pending(irq_pending), .irq_vector(irq_vector),
        .pri_req(pri_req), .sec_req(sec_req), .pri_isr(pri_isr), .sec_isr(sec_isr),
        .pri_trig(pri_trig), .sec_trig(sec_trig)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic line_evt(input bit raise, input int line);
        @(negedge clk);
        evt_valid = 1; evt_raise = raise; evt_line = 4'(line);
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic do_ack(input int vec);
        @(negedge clk);
        ack_valid = 1; ack_vector = 8'(vec);
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic trig_write(input bit sel, input int data);
        @(negedge clk);
        trig_wr_en = 1; trig_wr_sel = sel; trig_wr_data = 8'(data);
        @(negedge clk);
        trig_wr_en = 0;
    endtask

    task automatic eoi(input bit sec, input int mask);
        @(negedge clk);
        if (sec) begin sec_eoi_valid = 1; sec_eoi_mask = 8'(mask); end
        else begin pri_eoi_valid = 1; pri_eoi_mask = 8'(mask); end
        @(negedge clk);
        sec_eoi_valid = 0; pri_eoi_valid = 0;
    endtask

    task automatic t_reset();
        chk("R10", "pri_trig reset", pri_trig, 0);
        chk("R10", "sec_trig reset", sec_trig, 0);
        chk("R4", "pending reset", irq_pending, 0);
        chk("R1", "requests reset", {pri_req, sec_req}, 0);
        chk("R7", "in-service reset", {pri_isr, sec_isr}, 0);
    endtask

    task automatic t_raise();
        line_evt(1, 5);
        chk("R1", "pri_req after raise 5", pri_req, 8'h20);
        chk("R4", "pending after raise 5", irq_pending, 1);
        chk("R6", "vector primary 5", irq_vector, 8'h25);
        line_evt(1, 12);
        chk("R1", "sec_req after raise 12", sec_req, 8'h10);
        chk("R1", "cascade bit after raise 12", pri_req, 8'h24);
        chk("R5", "secondary beats primary 5", irq_vector, 8'h2C);
    endtask

    task automatic t_priority();
        line_evt(1, 1);
        chk("R5", "primary 1 beats secondary", irq_vector, 8'h21);
        line_evt(0, 1);
        chk("R3", "lower primary 1", pri_req, 8'h24);
        chk("R5", "back to secondary 12", irq_vector, 8'h2C);
    endtask

    task automatic t_redirect();
        line_evt(1, 2);
        chk("R2", "line 2 sets secondary 1", sec_req, 8'h12);
        chk("R2", "line 2 leaves primary bit 2 only", pri_req, 8'h24);
        chk("R5", "line 9 outranks 12", irq_vector, 8'h29);
        line_evt(0, 2);
        chk("R2", "lower line 2 clears secondary 1", sec_req, 8'h10);
        chk("R3", "cascade kept with 12 live", pri_req, 8'h24);
    endtask

    task automatic t_gate();
        @(negedge clk); pri_mask = 8'h04;
        @(negedge clk);
        chk("R5", "gated secondary, vector primary 5", irq_vector, 8'h25);
        pri_mask = 8'h24;
        @(negedge clk);
        chk("R4", "all gated, not pending", irq_pending, 0);
        chk("R6", "no selection vector", irq_vector, 0);
        pri_mask = 8'h00;
    endtask

    task automatic t_lower_sec();
        line_evt(1, 13);
        @(negedge clk); sec_mask = 8'h20;
        line_evt(0, 12);
        chk("R3", "sec_req after lower 12", sec_req, 8'h20);
        chk("R3", "cascade cleared, only masked left", pri_req, 8'h20);
        line_evt(0, 13);
        chk("R3", "sec_req empty", sec_req, 8'h00);
        @(negedge clk); sec_mask = 8'h00;
    endtask

    task automatic t_ack_primary();
        do_ack(8'h25);
        chk("R7", "pri_isr after edge ack", pri_isr, 8'h20);
        chk("R7", "edge request cleared", pri_req, 8'h00);
        chk("R4", "nothing pending", irq_pending, 0);
    endtask

    task automatic t_trig();
        trig_write(0, 8'hFF);
        chk("R10", "primary trig masked", pri_trig, 8'hF8);
        trig_write(1, 8'hFF);
        chk("R10", "secondary trig masked", sec_trig, 8'hDE);
        chk("R10", "primary trig untouched", pri_trig, 8'hF8);
        line_evt(1, 3);
        do_ack(8'h23);
        chk("R7", "level ack sets isr", pri_isr, 8'h28);
        chk("R7", "level request kept", pri_req, 8'h08);
        line_evt(0, 3);
    endtask

    task automatic t_ack_secondary();
        line_evt(1, 8);
        do_ack(8'h28);
        chk("R8", "sec_isr edge", sec_isr, 8'h01);
        chk("R8", "cascade in service", pri_isr, 8'h2C);
        chk("R8", "edge sec request cleared", sec_req, 8'h00);
        chk("R8", "cascade request cleared", pri_req, 8'h00);
        line_evt(1, 9);
        do_ack(8'h29);
        chk("R8", "sec_isr level", sec_isr, 8'h03);
        chk("R8", "level sec request kept", sec_req, 8'h02);
        chk("R8", "cascade edge cleared", pri_req, 8'h00);
    endtask

    task automatic t_ack_ignored();
        do_ack(8'h50);
        chk("R9", "foreign ack pri_req", pri_req, 8'h00);
        chk("R9", "foreign ack sec_req", sec_req, 8'h02);
        chk("R9", "foreign ack isrs", {pri_isr, sec_isr}, 16'h2C03);
        do_ack(8'h26);
        chk("R9", "idle primary ack isrs", {pri_isr, sec_isr}, 16'h2C03);
        do_ack(8'h2F);
        chk("R9", "idle secondary ack isrs", {pri_isr, sec_isr}, 16'h2C03);
        chk("R9", "idle acks requests", {pri_req, sec_req}, 16'h0002);
    endtask

    task automatic t_eoi();
        eoi(0, 8'h20);
        chk("R11", "primary eoi clears bit 5", pri_isr, 8'h0C);
        line_evt(1, 9);
        chk("R1", "cascade raised again", pri_req, 8'h04);
        eoi(1, 8'h01);
        chk("R11", "secondary eoi clears bit 0", sec_isr, 8'h02);
        chk("R11", "cascade kept, sec not empty", pri_req, 8'h04);
        line_evt(0, 9);
        chk("R3", "lower 9 clears cascade", pri_req, 8'h00);
    endtask

    task automatic t_timing();
        @(negedge clk);
        evt_valid = 1; evt_raise = 1; evt_line = 4'd7;
        #5;
        chk("R12", "no change before edge", pri_req, 8'h00);
        @(negedge clk);
        evt_valid = 0;
        chk("R12", "changed after edge", pri_req, 8'h80);
        chk("R12", "vector follows register", irq_vector, 8'h27);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_raise();
        t_priority();
        t_redirect();
        t_gate();
        t_lower_sec();
        t_ack_primary();
        t_trig();
        t_ack_secondary();
        t_ack_ignored();
        t_eoi();
        t_timing();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule